// File: doc/BRIEF.md
# Wrap-Around Partial-Sum Accumulator

This block reduces a stream of packed integer groups to sums while keeping a multi-cycle pipelined adder busy. Each accepted group of `LANES` operands is added lane-wise into one of `SLICES = ADD_LAT / ADD_II` partial-sum slices. The slice pointer advances round-robin on every accepted group. By the time it wraps back to a slice, that slice's earlier sum is leaving the adder, so a new group can be issued every `ADD_II` cycles with no stall. Slice entries are `ACC_W` bits wide, which is wider than the `IN_W`-bit operands. Operands are therefore extended once, at the adder input, and never need to be promoted ahead of time.

A run begins with a `start` pulse. `mode_sec` selects the mode: 0 gives a total reduction, 1 gives section mode. In total mode, `finish` closes the input. The block then waits for the adder pipeline to drain, folds every slice into one scalar and offers that scalar as a single beat on the output stream. In section mode, the input is treated as a flat sequence of elements, lane 0 of each group first. One sum is emitted for every `sec_len` consecutive elements, and a section boundary may fall anywhere inside a group.

Top module: `wrap_accum`

## Requirements
- R1: After reset, and whenever no run is active, `in_ready` and `out_valid` are both 0.
- R2: In total mode with `ADD_II` = 1, `in_ready` stays high every cycle until `finish` is taken. With a larger interval, two accepted groups are at least `ADD_II` cycles apart.
- R3: In total mode, the single output beat equals the sum, modulo 2^`ACC_W`, of every lane of every accepted group. Lane i occupies `in_data[i*IN_W +: IN_W]`. A run with no groups returns 0.
- R4: Accepted groups go to slices 0, 1, …, `SLICES`-1, and then the rotation wraps to 0. A slice is never issued while its previous sum is still inside the adder, apart from the final stage, which is forwarded.
- R5: `start` clears all slices, so a run's result never includes values from an earlier run.
- R6: A group accepted in the same cycle as `finish` is included in the result. The fold begins only after the adder pipeline is empty.
- R7: In section mode (`mode_sec`=1), output beat m equals the sum of elements m·k … m·k+k−1, where k = `sec_len` ≥ 1 and elements are numbered group by group with lane 0 first. Beats appear in order.
- R8: Section boundaries that fall inside a group are honoured per element. This holds for k smaller than `LANES`, k not dividing `LANES`, and k larger than `LANES`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged. No beat is lost or repeated under backpressure.
- R10: In section mode, `finish` stops further input, and a trailing partial section is discarded. Once the last full section has been taken, the block returns to idle.
- R11: `start` is ignored while a run is active.
- R12: With `IN_SIGNED`=1, operands are sign-extended to `ACC_W`, so negative values reduce correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when idle, clearing the slices |
| mode_sec | input | 1 | Mode sampled on `start`: 0 = total, 1 = section |
| sec_len | input | KW | Section length k, sampled on `start` |
| finish | input | 1 | Closes the input of the current run |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Block accepts a group this cycle |
| in_data | input | LANES*IN_W | Packed group, lane 0 in the low bits |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | ACC_W | Total or section sum |

## Verification
The bench feeds groups with idle gaps between them, so the slice rotation falls out of step with time. It also runs a single group, an empty run and runs longer than the slice count. A design that read a slice without forwarding its last in-flight sum, or that folded before the pipeline drained, would drop groups from the total. The bench sweeps several section lengths, below, equal to and above the lane count and not dividing it, while throttling the output. A segmenter that reset its count per group, emitted a trailing partial section or advanced under backpressure would produce wrong beats, miss beats or produce extra beats. Runs repeated back to back and a `start` pulse driven mid-run expose slices that are not cleared, or a run that restarts when it should not.

// File: rtl/wrap_accum_pkg.sv
package wrap_accum_pkg;
   typedef enum logic [2:0] {
      WA_IDLE  = 3'd0,
      WA_ACC   = 3'd1,
      WA_DRAIN = 3'd2,
      WA_FOLD  = 3'd3,
      WA_EMIT  = 3'd4,
      WA_SEC   = 3'd5
   } wa_state_t;
endpackage

// File: rtl/wacc_slices.sv
// Rotating partial-sum slices in front of an ADD_LAT-stage adder pipeline.
module wacc_slices #(
   parameter int LANES     = 4,
   parameter int IN_W      = 8,
   parameter int ACC_W     = 32,
   parameter int ADD_LAT   = 3,
   parameter int SLICES    = 3,
   parameter int SW        = 2,
   parameter bit IN_SIGNED = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    issue,
   input  logic [LANES*IN_W-1:0]   grp,
   input  logic [SW-1:0]           rd_idx,
   output logic [ACC_W-1:0]        rd_sum,
   output logic [SW-1:0]           rot_ptr,
   output logic [SLICES-1:0]       inflight,
   output logic                    pipe_busy
);
   logic [ACC_W-1:0] ext_op  [LANES];
   logic [ACC_W-1:0] slice_q [SLICES][LANES];
   logic [ACC_W-1:0] stg_d   [ADD_LAT][LANES];
   logic [SW-1:0]    stg_i   [ADD_LAT];
   logic [ADD_LAT-1:0] stg_v;
   logic [SW-1:0]    rot_q;
   logic             fwd;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_ext
         if (IN_SIGNED) begin : g_sx
            assign ext_op[l] = {{(ACC_W-IN_W){grp[l*IN_W+IN_W-1]}}, grp[l*IN_W +: IN_W]};
         end else begin : g_zx
            assign ext_op[l] = {{(ACC_W-IN_W){1'b0}}, grp[l*IN_W +: IN_W]};
         end
      end
   endgenerate

   // The sum leaving the last stage belongs to the slice being re-issued
   // exactly ADD_LAT cycles later: bypass it instead of waiting a cycle.
   assign fwd = stg_v[ADD_LAT-1] && (stg_i[ADD_LAT-1] == rot_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_v <= '0;
         rot_q <= '0;
      end else begin
         for (int s = ADD_LAT-1; s > 0; s--) stg_v[s] <= stg_v[s-1];
         stg_v[0] <= issue;
         if (clr) rot_q <= '0;
         else if (issue) rot_q <= (rot_q == SW'(SLICES-1)) ? '0 : rot_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      for (int s = ADD_LAT-1; s > 0; s--) begin
         stg_i[s] <= stg_i[s-1];
         for (int l = 0; l < LANES; l++) stg_d[s][l] <= stg_d[s-1][l];
      end
      stg_i[0] <= rot_q;
      for (int l = 0; l < LANES; l++)
         stg_d[0][l] <= (fwd ? stg_d[ADD_LAT-1][l] : slice_q[rot_q][l]) + ext_op[l];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         for (int s = 0; s < SLICES; s++)
            for (int l = 0; l < LANES; l++) slice_q[s][l] <= '0;
      end else if (stg_v[ADD_LAT-1]) begin
         for (int l = 0; l < LANES; l++) slice_q[stg_i[ADD_LAT-1]][l] <= stg_d[ADD_LAT-1][l];
      end
   end

   always_comb begin
      inflight = '0;
      for (int s = 0; s < ADD_LAT-1; s++)
         if (stg_v[s]) inflight[stg_i[s]] = 1'b1;
      rd_sum = '0;
      for (int l = 0; l < LANES; l++) rd_sum = rd_sum + slice_q[rd_idx][l];
   end

   assign rot_ptr   = rot_q;
   assign pipe_busy = |stg_v;
endmodule

// File: rtl/wacc_section.sv
// Per-element section segmenter: walks a buffered group one lane per cycle.
module wacc_section #(
   parameter int LANES     = 4,
   parameter int IN_W      = 8,
   parameter int ACC_W     = 32,
   parameter int KW        = 8,
   parameter bit IN_SIGNED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [KW-1:0]         k_in,
   input  logic                  en,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [LANES*IN_W-1:0] grp,
   input  logic                  out_ready,
   output logic                  o_valid,
   output logic [ACC_W-1:0]      o_data,
   output logic                  idle
);
   localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

   logic [LANES*IN_W-1:0] buf_q;
   logic                  full_q;
   logic [LW-1:0]         lane_q;
   logic [ACC_W-1:0]      run_sum;
   logic [KW-1:0]         run_cnt, k_q;
   logic [IN_W-1:0]       raw;
   logic [ACC_W-1:0]      elem;
   logic                  step, close;

   assign raw = buf_q[int'(lane_q)*IN_W +: IN_W];
   generate
      if (IN_SIGNED) begin : g_sx
         assign elem = {{(ACC_W-IN_W){raw[IN_W-1]}}, raw};
      end else begin : g_zx
         assign elem = {{(ACC_W-IN_W){1'b0}}, raw};
      end
   endgenerate

   assign in_ready = en && !full_q;
   assign step     = full_q && (!o_valid || out_ready);
   assign close    = (run_cnt == k_q - KW'(1));
   assign idle     = !full_q && !o_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q <= '0; full_q <= 1'b0; lane_q <= '0;
         run_sum <= '0; run_cnt <= '0; k_q <= '0;
         o_valid <= 1'b0; o_data <= '0;
      end else begin
         if (go) begin
            k_q <= k_in; run_sum <= '0; run_cnt <= '0;
         end
         if (in_valid && in_ready) begin
            buf_q <= grp; full_q <= 1'b1; lane_q <= '0;
         end
         if (o_valid && out_ready) o_valid <= 1'b0;
         if (step) begin
            if (close) begin
               o_valid <= 1'b1;
               o_data  <= run_sum + elem;
               run_sum <= '0;
               run_cnt <= '0;
            end else begin
               run_sum <= run_sum + elem;
               run_cnt <= run_cnt + 1'b1;
            end
            if (lane_q == LW'(LANES-1)) full_q <= 1'b0;
            else lane_q <= lane_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wrap_accum.sv
module wrap_accum
   import wrap_accum_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int IN_W      = 8,
   parameter int ACC_W     = 32,
   parameter int ADD_LAT   = 3,
   parameter int ADD_II    = 1,
   parameter int KW        = 8,
   parameter bit IN_SIGNED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  mode_sec,
   input  logic [KW-1:0]         sec_len,
   input  logic                  finish,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [LANES*IN_W-1:0] in_data,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [ACC_W-1:0]      out_data
);
   localparam int SLICES = ADD_LAT / ADD_II;
   localparam int SW     = (SLICES > 1) ? $clog2(SLICES) : 1;
   localparam int IIW    = $clog2(ADD_II + 1);

   generate
      if (ADD_LAT % ADD_II != 0) begin : g_bad_ii
         $error("ADD_LAT must be a multiple of ADD_II");
      end
      if (ACC_W <= IN_W) begin : g_bad_w
         $error("ACC_W must exceed IN_W");
      end
      if (LANES < 1 || ADD_II < 1) begin : g_bad_n
         $error("LANES and ADD_II must be positive");
      end
   endgenerate

   wa_state_t        st;
   logic             fin_q;
   logic [SW-1:0]    fold_idx;
   logic [ACC_W-1:0] total;
   logic [IIW-1:0]   ii_cnt;
   logic             acc_ready, issue, clr;
   logic [ACC_W-1:0] rd_sum;
   logic [SW-1:0]    rot_ptr;
   logic [SLICES-1:0] inflight;
   logic             pipe_busy;
   logic             sec_in_ready, sec_valid, sec_idle;
   logic [ACC_W-1:0] sec_data;

   assign acc_ready = (ii_cnt == '0);
   assign issue     = (st == WA_ACC) && in_valid && acc_ready;
   assign clr       = (st == WA_IDLE) && start && !mode_sec;

   wacc_slices #(
      .LANES(LANES), .IN_W(IN_W), .ACC_W(ACC_W), .ADD_LAT(ADD_LAT),
      .SLICES(SLICES), .SW(SW), .IN_SIGNED(IN_SIGNED)
   ) i_slices (
      .clk(clk), .rst_n(rst_n), .clr(clr), .issue(issue), .grp(in_data),
      .rd_idx(fold_idx), .rd_sum(rd_sum), .rot_ptr(rot_ptr),
      .inflight(inflight), .pipe_busy(pipe_busy)
   );

   wacc_section #(
      .LANES(LANES), .IN_W(IN_W), .ACC_W(ACC_W), .KW(KW), .IN_SIGNED(IN_SIGNED)
   ) i_section (
      .clk(clk), .rst_n(rst_n), .go((st == WA_IDLE) && start && mode_sec),
      .k_in(sec_len), .en((st == WA_SEC) && !fin_q), .in_valid(in_valid),
      .in_ready(sec_in_ready), .grp(in_data), .out_ready(out_ready),
      .o_valid(sec_valid), .o_data(sec_data), .idle(sec_idle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ii_cnt <= '0;
      end else if (issue) begin
         ii_cnt <= IIW'(ADD_II - 1);
      end else if (ii_cnt != '0) begin
         ii_cnt <= ii_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= WA_IDLE;
         fin_q    <= 1'b0;
         fold_idx <= '0;
         total    <= '0;
      end else begin
         unique case (st)
            WA_IDLE:  if (start) begin
                         st    <= mode_sec ? WA_SEC : WA_ACC;
                         fin_q <= 1'b0;
                      end
            WA_ACC:   if (finish) st <= WA_DRAIN;
            WA_DRAIN: if (!pipe_busy) begin
                         st       <= WA_FOLD;
                         fold_idx <= '0;
                         total    <= '0;
                      end
            WA_FOLD:  begin
                         total <= total + rd_sum;
                         if (fold_idx == SW'(SLICES-1)) st <= WA_EMIT;
                         else fold_idx <= fold_idx + 1'b1;
                      end
            WA_EMIT:  if (out_ready) st <= WA_IDLE;
            WA_SEC:   begin
                         if (finish) fin_q <= 1'b1;
                         if (fin_q && sec_idle) st <= WA_IDLE;
                      end
            default:  st <= WA_IDLE;
         endcase
      end
   end

   assign in_ready  = (st == WA_ACC) ? acc_ready : sec_in_ready;
   assign out_valid = (st == WA_EMIT) || sec_valid;
   assign out_data  = (st == WA_EMIT) ? total : sec_data;
endmodule

// File: rtl/wrap_accum_chk.sv
module wrap_accum_chk
   import wrap_accum_pkg::*;
#(
   parameter int SLICES = 3,
   parameter int SW     = 2,
   parameter int ADD_II = 1,
   parameter int ACC_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input wa_state_t         st,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ACC_W-1:0]  out_data,
   input logic              issue,
   input logic [SW-1:0]     rot_ptr,
   input logic [SLICES-1:0] inflight,
   input logic              pipe_busy
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WA_IDLE) |-> (!in_ready && !out_valid));

   p_issue_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> ((ADD_II == 1) || !in_ready));

   p_no_reissue_r4: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !inflight[rot_ptr]);

   p_rot_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && rot_ptr == SW'(SLICES-1)) |=> (rot_ptr == '0));

   p_fold_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WA_FOLD) |-> !pipe_busy);

   p_hold_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind wrap_accum wrap_accum_chk #(
   .SLICES(SLICES), .SW(SW), .ADD_II(ADD_II), .ACC_W(ACC_W)
) i_wrap_accum_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .issue(issue), .rot_ptr(rot_ptr), .inflight(inflight), .pipe_busy(pipe_busy)
);

// File: tb/test_wrap_accum.sv
`timescale 1ns/1ps
module test_wrap_accum;
   localparam int LANES = 4;
   localparam int IN_W  = 8;
   localparam int ACC_W = 32;
   localparam int KW    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, mode_sec = 1'b0, finish = 1'b0;
   logic [KW-1:0] sec_len = '0;
   logic in_valid = 1'b0, out_ready = 1'b0;
   logic [LANES*IN_W-1:0] in_data = '0;
   logic in_ready, out_valid;
   logic [ACC_W-1:0] out_data;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   wrap_accum i_wrap_accum (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_sec(mode_sec),
      .sec_len(sec_len), .finish(finish), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [IN_W-1:0] el(input int seed, input int j);
      if (seed < 0) return 8'h80;
      return 8'(j * 37 + seed * 53 + 5);
   endfunction

   task automatic pulse_start(input bit sec, input int k);
      @(negedge clk);
      start = 1'b1; mode_sec = sec; sec_len = KW'(k);
      @(negedge clk);
      start = 1'b0; mode_sec = 1'b0;
   endtask

   task automatic send_groups(input int seed, input int ng, input bit gaps,
                              input bit poke, input bit acc_mode, output int miss);
      miss = 0;
      if (ng == 0) begin
         @(negedge clk); finish = 1'b1;
         @(negedge clk); finish = 1'b0;
         return;
      end
      for (int g = 0; g < ng; g++) begin
         bit taken = 1'b0;
         if (gaps && (g % 3 == 2)) repeat (2) @(negedge clk);
         while (!taken) begin
            @(negedge clk);
            in_valid = 1'b1;
            for (int l = 0; l < LANES; l++) in_data[l*IN_W +: IN_W] = el(seed, g*LANES + l);
            start = poke && (g == 1);
            mode_sec = start;
            #1;
            if (in_ready) begin
               finish = (g == ng - 1);
               taken = 1'b1;
            end else if (acc_mode) begin
               miss++;
            end
            @(posedge clk); #1;
            in_valid = 1'b0; finish = 1'b0; start = 1'b0; mode_sec = 1'b0;
         end
      end
   endtask

   task automatic run_total(input int seed, input int ng, input bit gaps, input bit poke);
      int miss;
      longint expv = 0;
      int w = 0;
      logic [ACC_W-1:0] d0;
      for (int j = 0; j < ng*LANES; j++) expv += longint'($signed(el(seed, j)));
      pulse_start(1'b0, 0);
      send_groups(seed, ng, gaps, poke, 1'b1, miss);
      chk(miss == 0, "R2 ready stalls in total mode", miss, 0);
      @(negedge clk);
      while (!out_valid && w < 40) begin @(negedge clk); w++; end
      chk(out_valid, "R3 result beat present", out_valid, 1);
      d0 = out_data;
      for (int h = 0; h < 3; h++) begin
         @(negedge clk);
         chk(out_valid && out_data == d0, "R9 held under backpressure", out_data, d0);
      end
      out_ready = 1'b1;
      chk(out_data == ACC_W'(expv), "R3 R4 R5 R6 R11 R12 total sum",
          longint'($signed(out_data)), expv);
      @(negedge clk);
      out_ready = 1'b0;
      chk(!out_valid && !in_ready, "R1 quiet after result", {out_valid, in_ready}, 0);
   endtask

   task automatic collect(input int seed, input int ng, input int k);
      int got = 0;
      bit stall = 1'b0;
      logic [ACC_W-1:0] held = '0;
      int n = ng * LANES;
      for (int c = 0; c < 160; c++) begin
         @(negedge clk);
         out_ready = (c % 3 != 1);
         #1;
         if (stall) chk(out_valid && out_data == held, "R9 section beat held", out_data, held);
         stall = 1'b0;
         if (out_valid) begin
            if (out_ready) begin
               longint expv = 0;
               for (int i = 0; i < k; i++) expv += longint'($signed(el(seed, got*k + i)));
               chk(got < n / k && out_data == ACC_W'(expv), "R7 R8 section sum",
                   longint'($signed(out_data)), expv);
               got++;
            end else begin
               stall = 1'b1;
               held = out_data;
            end
         end
      end
      out_ready = 1'b0;
      chk(got == n / k, "R7 R10 section count", got, n / k);
      chk(!in_ready && !out_valid, "R10 idle after sections", {in_ready, out_valid}, 0);
   endtask

   task automatic run_section(input int seed, input int ng, input int k);
      int miss;
      pulse_start(1'b1, k);
      fork
         send_groups(seed, ng, 1'b0, 1'b0, 1'b0, miss);
         collect(seed, ng, k);
      join
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!in_ready && !out_valid, "R1 reset state", {in_ready, out_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!in_ready && !out_valid, "R1 idle after reset", {in_ready, out_valid}, 0);

      run_total(1, 1, 1'b0, 1'b0);
      run_total(2, 3, 1'b0, 1'b0);
      run_total(3, 7, 1'b1, 1'b0);
      run_total(4, 20, 1'b1, 1'b0);
      run_total(5, 0, 1'b0, 1'b0);
      run_total(6, 5, 1'b0, 1'b1);
      run_total(-1, 5, 1'b0, 1'b0);

      run_section(7, 5, 1);
      run_section(8, 5, 2);
      run_section(9, 5, 3);
      run_section(10, 5, 4);
      run_section(11, 5, 5);
      run_section(12, 5, 7);
      run_section(-1, 3, 3);

      run_total(13, 4, 1'b1, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule